// File: doc/BRIEF.md
# Bidirectional Port with Change Interrupt

This block is an 8-bit general-purpose I/O port built from one slice per pin. Each slice keeps an output value latch and a direction latch, both loaded from a shared bus data word. A per-pin select can hand the pin over to a peripheral, which then supplies both the driven value and the drive enable. The pin level is registered once per clock. A port read returns that registered pin level, not the output latch, so software sees what is actually on the wires.

The upper pins (4 to 7 by default) also feed a shared change detector. Each port read stores the sampled levels of these pins as a reference. Any later difference between a new sample and the reference raises one sticky change flag, which software clears with a strobe. A single active-low enable turns on weak pull-ups for pins configured as inputs. A low-voltage-programming input removes pin 4 from both the pull-up and the change detector.

Top module: `gpio_port_ioc`

## Requirements
- R1: A clock edge with `port_wr_i` high loads `bus_wdata_i` into the output latches. With `per_sel_i[i]` low, `pin_out_o[i]` equals output latch bit i. After reset the output latches are 0.
- R2: A clock edge with `dir_wr_i` high loads `bus_wdata_i` into the direction latches. Bit value 1 means input and 0 means output. After reset every direction bit is 1. With `per_sel_i[i]` low, `pin_oe_o[i]` is the inverse of direction bit i.
- R3: `pin_in_i` is sampled on every clock edge. With `dir_rd_i` low, `bus_rdata_o` shows the sampled levels from the most recent edge, independent of the output latches.
- R4: With `dir_rd_i` high, `bus_rdata_o` shows the direction latches. `dir_rd_i` takes priority over a port read.
- R5: With `per_sel_i[i]` high, `pin_out_o[i]` equals `per_out_i[i]` instead of the output latch bit.
- R6: With `per_sel_i[i]` high, `pin_oe_o[i]` equals `per_oe_i[i]`. With `per_sel_i[i]` low, `per_oe_i[i]` has no effect on `pin_oe_o[i]`.
- R7: `pin_pu_o[i]` is 1 exactly when `pull_en_n_i` is 0 and direction bit i is 1. Pin 4 is the exception covered by R11.
- R8: For pins 4 to 7, a sampled level that differs from the reference sets `chg_flag_o` on the next clock edge. Sample changes on pins 0 to 3 never set it.
- R9: A clock edge with `port_rd_i` high copies the current samples into the reference. The mismatch against the old reference still counts at that edge.
- R10: `chg_flag_o` stays 1 until an edge with `chg_clr_i` high and no mismatch. When a clear and a mismatch coincide, the flag stays set.
- R11: While `lvp_mode_i` is 1, pin 4 gets no pull-up and its changes do not set `chg_flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wdata_i | input | 8 | Write data for port and direction writes |
| port_wr_i | input | 1 | Output latch write strobe |
| dir_wr_i | input | 1 | Direction latch write strobe |
| port_rd_i | input | 1 | Port read strobe (updates the change reference) |
| dir_rd_i | input | 1 | Selects direction latches onto the read bus |
| bus_rdata_o | output | 8 | Read data: sampled pins or direction latches |
| pin_in_i | input | 8 | Pin input levels |
| pin_out_o | output | 8 | Driven pin values |
| pin_oe_o | output | 8 | Pin drive enables |
| pin_pu_o | output | 8 | Weak pull-up enables |
| per_sel_i | input | 8 | Per-pin peripheral select |
| per_out_i | input | 8 | Peripheral output values |
| per_oe_i | input | 8 | Peripheral drive enables |
| pull_en_n_i | input | 1 | Global active-low pull-up enable |
| lvp_mode_i | input | 1 | Low-voltage-programming mode for pin 4 |
| chg_clr_i | input | 1 | Change flag clear strobe |
| chg_flag_o | output | 1 | Sticky change-interrupt flag |

## Verification
The drive value, drive enable, pull-up and direction readback are combinational from the latches, so they are checked right after the write edge. A pin change first appears on the read bus one edge after it is applied, and the bench checks that the bus still shows the old sample before that edge. The change flag rises two edges after the pin moves: one edge to sample and one to set the flag. The bench checks the flag low after the first edge and high after the second. Clear and reference-update strobes are applied for a single edge, and their effect is checked just after that edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic {
      RD_PINS = 1'b0,
      RD_DIR  = 1'b1
   } rd_src_e;
endpackage

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice #(
   parameter bit IOC_PIN = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wbit_i,
   input  logic port_wr_i,
   input  logic dir_wr_i,
   input  logic pin_i,
   input  logic per_sel_i,
   input  logic per_out_i,
   input  logic per_oe_i,
   input  logic pull_en_n_i,
   input  logic strip_i,
   output logic out_o,
   output logic oe_o,
   output logic pu_o,
   output logic samp_o,
   output logic dir_o,
   output logic ioc_en_o
);
   logic data_q, dir_q, samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= 1'b0;
         dir_q  <= 1'b1;
         samp_q <= 1'b0;
      end else begin
         samp_q <= pin_i;
         if (port_wr_i) data_q <= wbit_i;
         if (dir_wr_i)  dir_q  <= wbit_i;
      end
   end

   always_comb begin
      out_o = per_sel_i ? per_out_i : data_q;
      oe_o  = per_sel_i ? per_oe_i  : ~dir_q;
      pu_o  = ~pull_en_n_i & dir_q & ~strip_i;
   end

   assign samp_o = samp_q;
   assign dir_o  = dir_q;

   generate
      if (IOC_PIN) begin : g_ioc
         assign ioc_en_o = ~strip_i;
      end else begin : g_plain
         assign ioc_en_o = 1'b0;
      end
   endgenerate

   a_r1_data_load: assert property (@(posedge clk) disable iff (!rst_n)
      port_wr_i |=> (data_q == $past(wbit_i)));
   a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
      dir_wr_i |=> (dir_q == $past(wbit_i)));
   a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_wr_i |=> $stable(dir_q));
   a_r3_sample: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (samp_q == $past(pin_i)));
endmodule

// File: rtl/gpio_ioc_detect.sv
module gpio_ioc_detect #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] samp_i,
   input  logic [WIDTH-1:0] en_i,
   input  logic             rd_i,
   input  logic             clr_i,
   output logic             flag_o
);
   logic [WIDTH-1:0] ref_q;
   logic             flag_q;
   logic             mism;

   assign mism = |((samp_i ^ ref_q) & en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (rd_i) ref_q <= samp_i;
         flag_q <= mism | (flag_q & ~clr_i);
      end
   end

   assign flag_o = flag_q;

   a_r9_ref_load: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> (ref_q == $past(samp_i)));
   a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
      mism |=> flag_q);
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !mism) |=> !flag_q);
endmodule

// File: rtl/gpio_port_ioc.sv
module gpio_port_ioc #(
   parameter int WIDTH   = 8,
   parameter int IOC_LO  = 4,
   parameter int LVP_IDX = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] bus_wdata_i,
   input  logic             port_wr_i,
   input  logic             dir_wr_i,
   input  logic             port_rd_i,
   input  logic             dir_rd_i,
   output logic [WIDTH-1:0] bus_rdata_o,
   input  logic [WIDTH-1:0] pin_in_i,
   output logic [WIDTH-1:0] pin_out_o,
   output logic [WIDTH-1:0] pin_oe_o,
   output logic [WIDTH-1:0] pin_pu_o,
   input  logic [WIDTH-1:0] per_sel_i,
   input  logic [WIDTH-1:0] per_out_i,
   input  logic [WIDTH-1:0] per_oe_i,
   input  logic             pull_en_n_i,
   input  logic             lvp_mode_i,
   input  logic             chg_clr_i,
   output logic             chg_flag_o
);
   import gpio_pkg::*;

   generate
      if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
         $error("WIDTH out of range");
      end
      if (IOC_LO < 0 || IOC_LO >= WIDTH) begin : g_bad_ioc
         $error("IOC_LO must index a pin");
      end
      if (LVP_IDX < 0 || LVP_IDX >= WIDTH) begin : g_bad_lvp
         $error("LVP_IDX must index a pin");
      end
   endgenerate

   logic [WIDTH-1:0] samp, dir, ioc_en;
   rd_src_e          rd_src;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic strip;
      assign strip = (i == LVP_IDX) ? lvp_mode_i : 1'b0;
      gpio_pin_slice #(.IOC_PIN(i >= IOC_LO)) i_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .wbit_i     (bus_wdata_i[i]),
         .port_wr_i  (port_wr_i),
         .dir_wr_i   (dir_wr_i),
         .pin_i      (pin_in_i[i]),
         .per_sel_i  (per_sel_i[i]),
         .per_out_i  (per_out_i[i]),
         .per_oe_i   (per_oe_i[i]),
         .pull_en_n_i(pull_en_n_i),
         .strip_i    (strip),
         .out_o      (pin_out_o[i]),
         .oe_o       (pin_oe_o[i]),
         .pu_o       (pin_pu_o[i]),
         .samp_o     (samp[i]),
         .dir_o      (dir[i]),
         .ioc_en_o   (ioc_en[i])
      );
   end

   gpio_ioc_detect #(.WIDTH(WIDTH)) i_ioc (
      .clk   (clk),
      .rst_n (rst_n),
      .samp_i(samp),
      .en_i  (ioc_en),
      .rd_i  (port_rd_i),
      .clr_i (chg_clr_i),
      .flag_o(chg_flag_o)
   );

   assign rd_src = dir_rd_i ? RD_DIR : RD_PINS;

   always_comb begin
      case (rd_src)
         RD_DIR:  bus_rdata_o = dir;
         default: bus_rdata_o = samp;
      endcase
   end

   a_r11_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
      lvp_mode_i |-> !pin_pu_o[LVP_IDX]);
   a_r2_reset_dir: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dir_wr_i) == 1'b0 && $past(rst_n) == 1'b0) |-> (dir == '1));
endmodule

// File: tb/test_gpio_port_ioc.sv
module test_gpio_port_ioc;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       port_wr = 1'b0, dir_wr = 1'b0, port_rd = 1'b0, dir_rd = 1'b0;
   logic [7:0] bus_rdata, pin_in = '0, pin_out, pin_oe, pin_pu;
   logic [7:0] per_sel = '0, per_out = '0, per_oe = '0;
   logic       pull_en_n = 1'b1, lvp_mode = 1'b0, chg_clr = 1'b0, chg_flag;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   gpio_port_ioc i_gpio_port_ioc (
      .clk(clk), .rst_n(rst_n), .bus_wdata_i(bus_wdata), .port_wr_i(port_wr),
      .dir_wr_i(dir_wr), .port_rd_i(port_rd), .dir_rd_i(dir_rd),
      .bus_rdata_o(bus_rdata), .pin_in_i(pin_in), .pin_out_o(pin_out),
      .pin_oe_o(pin_oe), .pin_pu_o(pin_pu), .per_sel_i(per_sel),
      .per_out_i(per_out), .per_oe_i(per_oe), .pull_en_n_i(pull_en_n),
      .lvp_mode_i(lvp_mode), .chg_clr_i(chg_clr), .chg_flag_o(chg_flag)
   );

   typedef struct packed {
      logic [7:0] data, dir, sel, pout, poe;
      logic       pull_n;
      logic [7:0] e_out, e_oe, e_pu;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hA5, 8'hFF, 8'h00},
      '{8'h3C, 8'hF0, 8'h0F, 8'h05, 8'h03, 1'b0, 8'h35, 8'h03, 8'hF0},
      '{8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 1'b1, 8'hFF, 8'h00, 8'h00},
      '{8'h00, 8'h5A, 8'hF0, 8'hC0, 8'hA0, 1'b0, 8'hC0, 8'hA5, 8'h5A}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic write_port(input logic [7:0] v);
      bus_wdata = v; port_wr = 1'b1; tick(); port_wr = 1'b0;
   endtask

   task automatic write_dir(input logic [7:0] v);
      bus_wdata = v; dir_wr = 1'b1; tick(); dir_wr = 1'b0;
   endtask

   task automatic read_port(output logic [7:0] v);
      dir_rd = 1'b0; port_rd = 1'b1; #1; v = bus_rdata; tick(); port_rd = 1'b0;
   endtask

   task automatic pulse_clr();
      chg_clr = 1'b1; tick(); chg_clr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rv;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      // reset state
      dir_rd = 1'b1; #1;
      chk("R2 reset dir", bus_rdata, 8'hFF);
      dir_rd = 1'b0;
      chk("R2 reset oe", pin_oe, 8'h00);
      chk("R1 reset out", pin_out, 8'h00);
      chk("R10 reset flag", {7'd0, chg_flag}, 8'h00);
      chk("R7 pull off", pin_pu, 8'h00);

      // vector table: R1 R2 R4 R5 R6 R7
      foreach (VECS[k]) begin
         write_port(VECS[k].data);
         write_dir(VECS[k].dir);
         per_sel = VECS[k].sel; per_out = VECS[k].pout; per_oe = VECS[k].poe;
         pull_en_n = VECS[k].pull_n;
         dir_rd = 1'b1; #1;
         chk($sformatf("R4 dir read v%0d", k), bus_rdata, VECS[k].dir);
         dir_rd = 1'b0; #1;
         chk($sformatf("R1/R5 out v%0d", k), pin_out, VECS[k].e_out);
         chk($sformatf("R2/R6 oe v%0d", k), pin_oe, VECS[k].e_oe);
         chk($sformatf("R7 pu v%0d", k), pin_pu, VECS[k].e_pu);
      end
      per_sel = '0; per_out = '0; per_oe = '0;

      // R3: read shows sampled pins, not latches
      write_port(8'hA5);
      pin_in = 8'h96; tick();
      read_port(rv);
      chk("R3 port read", rv, 8'h96);
      pin_in = 8'h11; #1;
      chk("R3 before edge", bus_rdata, 8'h96);
      tick();
      chk("R3 after edge", bus_rdata, 8'h11);

      // sync reference then clear
      pin_in = 8'h0F; tick();
      read_port(rv);
      pulse_clr();
      chk("R9 synced flag low", {7'd0, chg_flag}, 8'h00);

      // R8: low pins ignored
      pin_in = 8'h00; tick(); tick();
      chk("R8 low pins ignored", {7'd0, chg_flag}, 8'h00);

      // R8: pin 4 change, two-edge latency
      pin_in = 8'h10; tick();
      chk("R8 flag after one edge", {7'd0, chg_flag}, 8'h00);
      tick();
      chk("R8 flag after two edges", {7'd0, chg_flag}, 8'h01);

      // R10: set wins over clear
      pulse_clr();
      chk("R10 set wins", {7'd0, chg_flag}, 8'h01);
      read_port(rv);
      tick();
      chk("R10 sticky", {7'd0, chg_flag}, 8'h01);
      pulse_clr();
      chk("R9/R10 cleared after read", {7'd0, chg_flag}, 8'h00);

      // R11: LVP strips pin 4
      lvp_mode = 1'b1; pull_en_n = 1'b0;
      write_dir(8'hFF);
      chk("R11 pull-up stripped", pin_pu, 8'hEF);
      pin_in = 8'h00; tick(); tick();
      chk("R11 pin4 change ignored", {7'd0, chg_flag}, 8'h00);
      pin_in = 8'h80; tick(); tick();
      chk("R8 pin7 change under lvp", {7'd0, chg_flag}, 8'h01);
      lvp_mode = 1'b0; #1;
      chk("R7 pull-up restored", pin_pu, 8'hFF);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule